// File: doc/BRIEF.md
# Configuration Access Router

This block takes one configuration-space request at a time, named by bus, device, function and register offset, and steers it to one of two register-style ports. Requests for bus 0 land directly in the root port's own register space, with the register offset used as the address. Requests for any other bus go to a downstream window port in two steps. First, a full-word write to the index register selects the target bus, device and function. Then a second access, to the data window plus the register offset, carries the real read or write.

Before it opens any port, the router checks the request. On buses 0 and 1 only device 0 exists. No downstream access starts unless the link reports both data-link-active and PHY-link-up. A rejected request produces an error response with all-ones read data and causes no traffic on either port.

The request and response sides are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the response has been taken. The response holds `rsp_valid`, `rsp_rdata` and `rsp_err` steady until an edge with `rsp_ready` high. Each outbound port raises its valid, holds all its fields until an edge where its ready is high, and for a read takes its read data in that same cycle.

Top module: `cfg_route`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid`, `loc_valid` and `win_valid` are all 0.
- R2: A request to bus 0 or bus 1 with a device number other than 0 returns `rsp_err`=1 and `rsp_rdata`=32'hFFFFFFFF. It causes no transaction on either port.
- R3: A request to bus 0, device 0 makes exactly one local-port transaction. That transaction carries `loc_addr` equal to the offset zero-extended, plus the request's write flag, write data and byte enables. The response has `rsp_err`=0 and carries `loc_rdata` for a read and 0 for a write. This does not depend on the link status.
- R4: The link counts as up only when status bit 5 (data-link-active) and status bit 4 (PHY-link-up) are both 1. A request to any bus other than 0 while the link is down returns the all-ones error response with no port traffic.
- R5: A downstream request first makes a window write to address 16'h9000, with byte enables 4'hF. Its data holds the bus in bits 27:20, the device in bits 19:15 and the function in bits 14:12, and zeros elsewhere.
- R6: After the index write is accepted, `win_valid` stays low for at least one cycle. Then one window access goes to 16'h8000 plus the offset, with the request's write flag, data and byte enables. Its response has `rsp_err`=0 and carries `win_rdata` for a read and 0 for a write.
- R7: From acceptance until the response is taken, `req_ready` is 0. Only one port is active at any time.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, the response stays valid and its data and error flag do not change.
- R9: While an outbound valid is high and its ready is low, the valid stays high and its address, write flag, data and byte enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_stat | input | 8 | Link status word; bit 5 data-link-active, bit 4 PHY-link-up |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Router can accept a request |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Register offset in configuration space |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data, all ones on error |
| rsp_err | output | 1 | Request rejected |
| loc_valid | output | 1 | Local register access valid |
| loc_ready | input | 1 | Local access completes |
| loc_addr | output | 16 | Local register address |
| loc_wr | output | 1 | Local write flag |
| loc_wdata | output | 32 | Local write data |
| loc_be | output | 4 | Local byte enables |
| loc_rdata | input | 32 | Local read data, valid with loc_ready |
| win_valid | output | 1 | Window port access valid |
| win_ready | input | 1 | Window access completes |
| win_addr | output | 16 | Window port address (index or data window) |
| win_wr | output | 1 | Window write flag |
| win_wdata | output | 32 | Window write data |
| win_be | output | 4 | Window byte enables |
| win_rdata | input | 32 | Window read data, valid with win_ready |

## Verification
A wrong classification shows at the ports one edge after acceptance. Either an error response appears where a port access was due, or a `loc_valid`/`win_valid` pulse appears where only an error response should come. A bad field in the index word, or a lost offset in the data window, shows up on the window port before any response is returned, so the responder sees it within a few cycles. A broken ordering shows as `win_valid` high in the cycle right after the index handshake. A broken hold shows in the first stalled cycle as a changed field on a port, or as a changed response.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOC,
    ST_IDX,
    ST_GAP,
    ST_DAT,
    ST_RSP
  } cfgr_state_t;

  typedef enum logic [1:0] {
    CLS_ERR,
    CLS_LOCAL,
    CLS_DOWN
  } cfgr_cls_t;

endpackage

// File: rtl/cfgr_decode.sv
module cfgr_decode
  import cfgr_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int DEV_W    = 5,
  parameter int STAT_W   = 8,
  parameter int DLA_BIT  = 5,
  parameter int PHY_BIT  = 4,
  parameter int ONE_DEV_BUSES = 2
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [STAT_W-1:0] stat,
  output cfgr_cls_t         cls,
  output logic              link_up
);

  logic single_dev_bus;
  logic bad_dev;
  logic is_root;
  logic unused_stat;

  assign single_dev_bus = (bus < BUS_W'(ONE_DEV_BUSES));
  assign bad_dev        = single_dev_bus && (dev != '0);
  assign is_root        = (bus == '0);
  assign link_up        = stat[DLA_BIT] & stat[PHY_BIT];
  assign unused_stat    = ^stat;

  always_comb begin
    if (bad_dev)       cls = CLS_ERR;
    else if (is_root)  cls = CLS_LOCAL;
    else if (!link_up) cls = CLS_ERR;
    else               cls = CLS_DOWN;
  end

endmodule

// File: rtl/cfgr_master.sv
module cfgr_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic              s_wr,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [BE_W-1:0]   s_be,
  output logic              done,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_wr,
  output logic [DATA_W-1:0] m_wdata,
  output logic [BE_W-1:0]   m_be
);

  assign done = m_valid && m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_addr  <= '0;
      m_wr    <= 1'b0;
      m_wdata <= '0;
      m_be    <= '0;
    end else if (start) begin
      m_valid <= 1'b1;
      m_addr  <= s_addr;
      m_wr    <= s_wr;
      m_wdata <= s_wdata;
      m_be    <= s_be;
    end else if (done) begin
      m_valid <= 1'b0;
    end
  end

  // R9: a stalled access keeps every field
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_wr)
                               && $stable(m_wdata) && $stable(m_be)));

  // R7: no new access launched while one is still open
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !start);

endmodule

// File: rtl/cfg_route.sv
module cfg_route
  import cfgr_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int DEV_W    = 5,
  parameter int FN_W     = 3,
  parameter int OFF_W    = 12,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int STAT_W   = 8,
  parameter int DLA_BIT  = 5,
  parameter int PHY_BIT  = 4,
  parameter logic [ADDR_W-1:0] IDX_ADDR  = 16'h9000,
  parameter logic [ADDR_W-1:0] DATA_BASE = 16'h8000,
  localparam int BE_W    = DATA_W / 8,
  localparam int FN_LSB  = 12,
  localparam int DEV_LSB = FN_LSB + FN_W,
  localparam int BUS_LSB = DEV_LSB + DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] link_stat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              loc_valid,
  input  logic              loc_ready,
  output logic [ADDR_W-1:0] loc_addr,
  output logic              loc_wr,
  output logic [DATA_W-1:0] loc_wdata,
  output logic [BE_W-1:0]   loc_be,
  input  logic [DATA_W-1:0] loc_rdata,
  output logic              win_valid,
  input  logic              win_ready,
  output logic [ADDR_W-1:0] win_addr,
  output logic              win_wr,
  output logic [DATA_W-1:0] win_wdata,
  output logic [BE_W-1:0]   win_be,
  input  logic [DATA_W-1:0] win_rdata
);

  cfgr_state_t       st;
  cfgr_cls_t         cls;
  logic              link_up;
  logic              accept;
  logic              loc_start, loc_done;
  logic              win_start, win_done;
  logic [ADDR_W-1:0] win_s_addr;
  logic              win_s_wr;
  logic [DATA_W-1:0] win_s_wdata;
  logic [BE_W-1:0]   win_s_be;
  logic [DATA_W-1:0] index_word;
  logic [OFF_W-1:0]  q_off;
  logic              q_wr;
  logic [DATA_W-1:0] q_wdata;
  logic [BE_W-1:0]   q_be;

  cfgr_decode #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .STAT_W(STAT_W),
    .DLA_BIT(DLA_BIT), .PHY_BIT(PHY_BIT), .ONE_DEV_BUSES(2)
  ) u_decode (
    .bus(req_bus), .dev(req_dev), .stat(link_stat),
    .cls(cls), .link_up(link_up)
  );

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign loc_start = accept && (cls == CLS_LOCAL);
  assign win_start = (accept && (cls == CLS_DOWN)) || (st == ST_GAP);

  always_comb begin
    index_word = '0;
    index_word[BUS_LSB +: BUS_W] = req_bus;
    index_word[DEV_LSB +: DEV_W] = req_dev;
    index_word[FN_LSB  +: FN_W]  = req_fn;
  end

  always_comb begin
    if (st == ST_GAP) begin
      win_s_addr  = DATA_BASE + ADDR_W'(q_off);
      win_s_wr    = q_wr;
      win_s_wdata = q_wdata;
      win_s_be    = q_be;
    end else begin
      win_s_addr  = IDX_ADDR;
      win_s_wr    = 1'b1;
      win_s_wdata = index_word;
      win_s_be    = '1;
    end
  end

  cfgr_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_loc (
    .clk(clk), .rst_n(rst_n), .start(loc_start),
    .s_addr(ADDR_W'(req_off)), .s_wr(req_wr), .s_wdata(req_wdata), .s_be(req_be),
    .done(loc_done),
    .m_valid(loc_valid), .m_ready(loc_ready), .m_addr(loc_addr),
    .m_wr(loc_wr), .m_wdata(loc_wdata), .m_be(loc_be)
  );

  cfgr_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_win (
    .clk(clk), .rst_n(rst_n), .start(win_start),
    .s_addr(win_s_addr), .s_wr(win_s_wr), .s_wdata(win_s_wdata), .s_be(win_s_be),
    .done(win_done),
    .m_valid(win_valid), .m_ready(win_ready), .m_addr(win_addr),
    .m_wr(win_wr), .m_wdata(win_wdata), .m_be(win_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      q_off     <= '0;
      q_wr      <= 1'b0;
      q_wdata   <= '0;
      q_be      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          q_off   <= req_off;
          q_wr    <= req_wr;
          q_wdata <= req_wdata;
          q_be    <= req_be;
          unique case (cls)
            CLS_LOCAL: st <= ST_LOC;
            CLS_DOWN:  st <= ST_IDX;
            default: begin
              st        <= ST_RSP;
              rsp_valid <= 1'b1;
              rsp_rdata <= '1;
              rsp_err   <= 1'b1;
            end
          endcase
        end
        ST_LOC: if (loc_done) begin
          st        <= ST_RSP;
          rsp_valid <= 1'b1;
          rsp_rdata <= q_wr ? '0 : loc_rdata;
          rsp_err   <= 1'b0;
        end
        ST_IDX: if (win_done) st <= ST_GAP;
        ST_GAP: st <= ST_DAT;
        ST_DAT: if (win_done) begin
          st        <= ST_RSP;
          rsp_valid <= 1'b1;
          rsp_rdata <= q_wr ? '0 : win_rdata;
          rsp_err   <= 1'b0;
        end
        ST_RSP: if (rsp_ready) begin
          st        <= ST_IDLE;
          rsp_valid <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: busy while a response is pending; ports never both active
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  p_one_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_valid && win_valid));

  // R8: response held under back-pressure
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R2: bad device on a single-device bus gives an immediate error
  p_bad_dev_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_bus < 8'd2) && (req_dev != '0))
      |=> (rsp_valid && rsp_err && (rsp_rdata == '1) && !loc_valid && !win_valid));

  // R4: link down blocks every downstream request
  p_link_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_bus != '0) && !link_up)
      |=> (rsp_valid && rsp_err && !win_valid));

  // R6: an idle cycle separates the index handshake and the data access
  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ready && (win_addr == IDX_ADDR)) |=> !win_valid);

  // R3: local traffic only for bus 0, device 0
  p_local_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !((req_bus == '0) && (req_dev == '0))) |=> !loc_valid);

endmodule

// File: tb/cfg_route_test.sv
module cfg_route_test;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  link_stat = 8'h00;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [11:0] req_off = '0;
  logic        req_wr = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        loc_valid;
  logic        loc_ready;
  logic [15:0] loc_addr;
  logic        loc_wr;
  logic [31:0] loc_wdata;
  logic [3:0]  loc_be;
  logic [31:0] loc_rdata;
  logic        win_valid;
  logic        win_ready;
  logic [15:0] win_addr;
  logic        win_wr;
  logic [31:0] win_wdata;
  logic [3:0]  win_be;
  logic [31:0] win_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int loc_delay = 0, win_delay = 0;
  int loc_cnt = 0, win_cnt = 0;
  int loc_txn = 0, win_txn = 0;
  logic [15:0] l_addr; logic l_wr; logic [31:0] l_wdata; logic [3:0] l_be;
  logic [15:0] i_addr; logic i_wr; logic [31:0] i_wdata; logic [3:0] i_be;
  logic [15:0] d_addr; logic d_wr; logic [31:0] d_wdata; logic [3:0] d_be;
  int idx_cyc = 0, dat_first = 0;
  logic dat_seen = 1'b0;
  logic [31:0] r_data;
  logic        r_err;

  cfg_route uut (
    .clk(clk), .rst_n(rst_n), .link_stat(link_stat),
    .req_valid(req_valid), .req_ready(req_ready), .req_bus(req_bus),
    .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off), .req_wr(req_wr),
    .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_addr(loc_addr), .loc_wr(loc_wr),
    .loc_wdata(loc_wdata), .loc_be(loc_be), .loc_rdata(loc_rdata),
    .win_valid(win_valid), .win_ready(win_ready), .win_addr(win_addr), .win_wr(win_wr),
    .win_wdata(win_wdata), .win_be(win_be), .win_rdata(win_rdata)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  // local register responder
  initial begin
    loc_ready = 1'b0; loc_rdata = '0;
    forever begin
      @(negedge clk);
      if (loc_ready) loc_ready = 1'b0;
      else if (loc_valid) begin
        if (loc_cnt < loc_delay) loc_cnt++;
        else begin
          loc_cnt = 0; loc_txn++;
          l_addr = loc_addr; l_wr = loc_wr; l_wdata = loc_wdata; l_be = loc_be;
          loc_rdata = 32'hC0DE_0000 | {16'h0, loc_addr};
          loc_ready = 1'b1;
        end
      end
    end
  end

  // downstream window responder
  initial begin
    win_ready = 1'b0; win_rdata = '0;
    forever begin
      @(negedge clk);
      if (win_ready) win_ready = 1'b0;
      else if (win_valid) begin
        if (win_addr != 16'h9000 && !dat_seen) begin
          dat_seen = 1'b1; dat_first = cyc;
        end
        if (win_cnt < win_delay) win_cnt++;
        else begin
          win_cnt = 0; win_txn++;
          if (win_addr == 16'h9000) begin
            i_addr = win_addr; i_wr = win_wr; i_wdata = win_wdata; i_be = win_be;
            idx_cyc = cyc;
          end else begin
            d_addr = win_addr; d_wr = win_wr; d_wdata = win_wdata; d_be = win_be;
          end
          win_rdata = 32'h5A00_0000 | {16'h0, win_addr};
          win_ready = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn,
                        input logic [11:0] off, input logic wr, input logic [31:0] wd,
                        input logic [3:0] be, input int hold);
    logic [31:0] held_d;
    logic held_e;
    int guard;
    @(negedge clk);
    req_bus = bus; req_dev = dev; req_fn = fn; req_off = off;
    req_wr = wr; req_wdata = wd; req_be = be; req_valid = 1'b1;
    dat_seen = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 ready low after accept", {31'h0, req_ready}, 32'h0);
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      @(negedge clk); guard++;
      if (!rsp_valid) chk("R7 ready low while busy", {31'h0, req_ready}, 32'h0);
    end
    held_d = rsp_rdata; held_e = rsp_err;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R8 rsp_valid held", {31'h0, rsp_valid}, 32'h1);
      chk("R8 rdata held", rsp_rdata, held_d);
      chk("R8 err held", {31'h0, rsp_err}, {31'h0, held_e});
      chk("R7 ready low under back-pressure", {31'h0, req_ready}, 32'h0);
    end
    rsp_ready = 1'b1;
    r_data = rsp_rdata; r_err = rsp_err;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R7 rsp cleared after take", {31'h0, rsp_valid}, 32'h0);
    chk("R7 ready back after take", {31'h0, req_ready}, 32'h1);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1 loc_valid", {31'h0, loc_valid}, 32'h0);
    chk("R1 win_valid", {31'h0, win_valid}, 32'h0);
  endtask

  task automatic t_local;
    int lt;
    link_stat = 8'h00;
    lt = loc_txn;
    do_req(8'd0, 5'd0, 3'd0, 12'h04C, 1'b1, 32'hDEAD_BEEF, 4'h3, 0);
    chk("R3 one local txn", loc_txn - lt, 1);
    chk("R3 loc_addr", {16'h0, l_addr}, 32'h0000_004C);
    chk("R3 loc_wr", {31'h0, l_wr}, 32'h1);
    chk("R3 loc_wdata", l_wdata, 32'hDEAD_BEEF);
    chk("R3 loc_be", {28'h0, l_be}, 32'h3);
    chk("R3 write rdata", r_data, 32'h0);
    chk("R3 write err", {31'h0, r_err}, 32'h0);
    loc_delay = 3;
    do_req(8'd0, 5'd0, 3'd5, 12'h010, 1'b0, 32'h0, 4'hF, 0);
    loc_delay = 0;
    chk("R9 stalled local addr", {16'h0, l_addr}, 32'h0000_0010);
    chk("R3 local read data", r_data, 32'hC0DE_0010);
    chk("R3 local read err", {31'h0, r_err}, 32'h0);
  endtask

  task automatic t_bad_dev;
    int lt, wt;
    link_stat = 8'h30;
    lt = loc_txn; wt = win_txn;
    do_req(8'd0, 5'd3, 3'd0, 12'h000, 1'b1, 32'h1234_5678, 4'hF, 0);
    chk("R2 bus0 dev3 err", {31'h0, r_err}, 32'h1);
    chk("R2 bus0 dev3 rdata", r_data, 32'hFFFF_FFFF);
    do_req(8'd1, 5'd1, 3'd0, 12'h008, 1'b0, 32'h0, 4'hF, 0);
    chk("R2 bus1 dev1 err", {31'h0, r_err}, 32'h1);
    chk("R2 bus1 dev1 rdata", r_data, 32'hFFFF_FFFF);
    chk("R2 no local traffic", loc_txn - lt, 0);
    chk("R2 no window traffic", win_txn - wt, 0);
  endtask

  task automatic t_link_down;
    int wt;
    wt = win_txn;
    link_stat = 8'h20;
    do_req(8'd2, 5'd0, 3'd0, 12'h000, 1'b0, 32'h0, 4'hF, 0);
    chk("R4 phy down err", {31'h0, r_err}, 32'h1);
    chk("R4 phy down rdata", r_data, 32'hFFFF_FFFF);
    link_stat = 8'hDF & 8'hFF & ~8'h20;
    do_req(8'd9, 5'd4, 3'd1, 12'h100, 1'b1, 32'hAAAA_5555, 4'hF, 0);
    chk("R4 dl down err", {31'h0, r_err}, 32'h1);
    chk("R4 no window traffic", win_txn - wt, 0);
    link_stat = 8'h00;
    do_req(8'd0, 5'd0, 3'd0, 12'h020, 1'b0, 32'h0, 4'hF, 0);
    chk("R4 bus0 ok with link down", {31'h0, r_err}, 32'h0);
  endtask

  task automatic t_down_read;
    int wt;
    link_stat = 8'h30;
    wt = win_txn;
    do_req(8'd5, 5'd7, 3'd2, 12'h1FC, 1'b0, 32'h0, 4'hF, 0);
    chk("R5 two window txns", win_txn - wt, 2);
    chk("R5 index addr", {16'h0, i_addr}, 32'h0000_9000);
    chk("R5 index wr", {31'h0, i_wr}, 32'h1);
    chk("R5 index word", i_wdata, (32'd5 << 20) | (32'd7 << 15) | (32'd2 << 12));
    chk("R5 index be", {28'h0, i_be}, 32'hF);
    chk("R6 data addr", {16'h0, d_addr}, 32'h0000_81FC);
    chk("R6 data wr", {31'h0, d_wr}, 32'h0);
    chk("R6 gap after index", {31'h0, dat_seen && (dat_first - idx_cyc >= 2)}, 32'h1);
    chk("R6 read data", r_data, 32'h5A00_81FC);
    chk("R6 read err", {31'h0, r_err}, 32'h0);
  endtask

  task automatic t_down_write;
    link_stat = 8'hFF;
    win_delay = 2;
    do_req(8'd1, 5'd0, 3'd7, 12'h020, 1'b1, 32'h0BAD_F00D, 4'h8, 0);
    win_delay = 0;
    chk("R5 bus1 index word", i_wdata, (32'd1 << 20) | (32'd7 << 12));
    chk("R9 stalled data addr", {16'h0, d_addr}, 32'h0000_8020);
    chk("R6 data wr", {31'h0, d_wr}, 32'h1);
    chk("R6 data wdata", d_wdata, 32'h0BAD_F00D);
    chk("R6 data be", {28'h0, d_be}, 32'h8);
    chk("R6 write rdata", r_data, 32'h0);
    chk("R6 write err", {31'h0, r_err}, 32'h0);
  endtask

  task automatic t_backpressure;
    link_stat = 8'h30;
    do_req(8'd0, 5'd0, 3'd0, 12'h0A4, 1'b0, 32'h0, 4'hF, 3);
    chk("R8 local data after stall", r_data, 32'hC0DE_00A4);
    do_req(8'd1, 5'd2, 3'd0, 12'h0A4, 1'b0, 32'h0, 4'hF, 3);
    chk("R8 error data after stall", r_data, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_local;
    t_bad_dev;
    t_link_down;
    t_down_read;
    t_down_write;
    t_backpressure;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule